// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block is an 8 KB data cache controller for a 32-bit byte-addressed processor. It has two ways and 16-byte lines. The processor side uses a simple request handshake. The controller accepts one word read or one word write at a time while it is idle. It signals completion with a one-cycle done pulse, and read data is valid in that same cycle. The memory side moves whole 128-bit lines. A request is held until memory answers with a done pulse.

Writes follow write-back and write-allocate rules. A write hit only marks the line dirty. A write miss first brings the line in and then writes the word. On a miss, the controller picks a victim from one recently-used bit per set. If the victim is dirty, the controller sends it to memory at an address rebuilt from its stored tag and the current set. Only after that does it fetch the new line. The controller then repeats the lookup, which now hits.

After reset, the controller clears every set before it accepts any work.

Top module: `wb_cache_ctrl`

## Requirements
- R1: A byte address splits into tag = addr[31:12], set = addr[11:4] and word select = addr[3:2]; word n of a line occupies line bits [32n+31:32n]. Every memory address has bits [3:0] at zero, and a writeback address equals {victim tag, current set, 4'b0}.
- R2: A read hit raises cpu_done, with the addressed word on cpu_rdata, in the first cycle after the accepting edge.
- R3: A write hit raises cpu_done in the second cycle after the accepting edge, and later reads of that word return the written value.
- R4: A miss whose victim is invalid or clean issues only a line read. With memory answering in its 12th cycle, a read completes in cycle 14.
- R5: A miss whose victim is dirty first writes the victim line back and then reads the new line. A read completes in cycle 26, and the written-back line carries the modified data.
- R6: A write miss fills the line and then writes the word, which costs one cycle more than the matching read miss (15 clean, 27 dirty).
- R7: The victim is way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the way not marked most recently used. Every hit and every fill marks the accessed way as most recently used.
- R8: cpu_ready is high only when the controller is idle and able to accept a request. Requests presented while cpu_ready is low are ignored and change nothing.
- R9: After reset, cpu_ready stays low for 256 cycles while every set is invalidated. Afterwards, every access misses until its line is filled.
- R10: mem_req, mem_we and mem_addr stay stable until mem_done. mem_we is high for a writeback and low for a refill. A hit makes no memory transfer, a clean miss makes one, and a dirty miss makes two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, taken when cpu_ready is high |
| cpu_we | input | 1 | 1 = word write, 0 = word read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | Idle and accepting |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read word, valid with cpu_done |
| mem_req | output | 1 | Line transfer request |
| mem_we | output | 1 | 1 = writeback, 0 = refill |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Victim line for writeback |
| mem_done | input | 1 | Memory completes the transfer |
| mem_rdata | input | 128 | Refill line, valid with mem_done |

## Verification
The hardest situation to reach from the ports is a dirty victim chosen by the recently-used bit rather than by an invalid way. Reaching it needs both ways of one set to be valid, the non-recent way to be dirty, and the recent way to be touched last. The stimulus table drives one set through a chain of hits, writes and conflicting tags so that each way in turn becomes dirty and non-recent. Each step's completion latency and writeback address reveal which way was evicted. A later read of the evicted word then proves that the written-back line carried the modified data.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    typedef enum logic [2:0] {
        ST_SWEEP  = 3'd0,
        ST_IDLE   = 3'd1,
        ST_ACCESS = 3'd2,
        ST_WRITE  = 3'd3,
        ST_WBACK  = 3'd4,
        ST_FILL   = 3'd5
    } wbc_state_e;

    localparam int WAYS = 2;
endpackage

// File: rtl/wbc_tag_array.sv
module wbc_tag_array #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 20
) (
    input  logic                               clk,
    input  logic [IDX_W-1:0]                   rd_idx,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic                               clr,
    input  logic                               fill_we,
    input  logic                               fill_way,
    input  logic [TAG_W-1:0]                   fill_tag,
    input  logic                               dirty_set,
    input  logic                               dirty_way,
    input  logic                               mru_we,
    input  logic                               mru_val,
    output logic [wbc_pkg::WAYS-1:0][TAG_W-1:0] rd_tag,
    output logic [wbc_pkg::WAYS-1:0]           rd_valid,
    output logic [wbc_pkg::WAYS-1:0]           rd_dirty,
    output logic                               rd_mru
);
    localparam int SETS = 1 << IDX_W;

    logic mru_mem [SETS];

    for (genvar w = 0; w < wbc_pkg::WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem   [SETS];
        logic             valid_mem [SETS];
        logic             dirty_mem [SETS];

        always_ff @(posedge clk) begin
            if (clr) begin
                valid_mem[wr_idx] <= 1'b0;
                dirty_mem[wr_idx] <= 1'b0;
            end else if (fill_we && fill_way == 1'(w)) begin
                tag_mem[wr_idx]   <= fill_tag;
                valid_mem[wr_idx] <= 1'b1;
                dirty_mem[wr_idx] <= 1'b0;
            end else if (dirty_set && dirty_way == 1'(w)) begin
                dirty_mem[wr_idx] <= 1'b1;
            end
        end

        assign rd_tag[w]   = tag_mem[rd_idx];
        assign rd_valid[w] = valid_mem[rd_idx];
        assign rd_dirty[w] = dirty_mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            mru_mem[wr_idx] <= 1'b0;
        end else if (mru_we) begin
            mru_mem[wr_idx] <= mru_val;
        end
    end

    assign rd_mru = mru_mem[rd_idx];
endmodule

// File: rtl/wbc_data_array.sv
module wbc_data_array #(
    parameter int IDX_W  = 8,
    parameter int LINE_W = 128,
    parameter int WORD_W = 32
) (
    input  logic                                clk,
    input  logic [IDX_W-1:0]                    rd_idx,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic                                line_we,
    input  logic                                line_way,
    input  logic [LINE_W-1:0]                   line_data,
    input  logic                                word_we,
    input  logic                                word_way,
    input  logic [$clog2(LINE_W/WORD_W)-1:0]    word_sel,
    input  logic [WORD_W-1:0]                   word_data,
    output logic [wbc_pkg::WAYS-1:0][LINE_W-1:0] rd_line
);
    localparam int SETS = 1 << IDX_W;

    for (genvar w = 0; w < wbc_pkg::WAYS; w++) begin : g_way
        logic [LINE_W-1:0] line_mem [SETS];

        always_ff @(posedge clk) begin
            if (line_we && line_way == 1'(w)) begin
                line_mem[wr_idx] <= line_data;
            end else if (word_we && word_way == 1'(w)) begin
                line_mem[wr_idx][word_sel*WORD_W +: WORD_W] <= word_data;
            end
        end

        assign rd_line[w] = line_mem[rd_idx];
    end
endmodule

// File: rtl/wbc_match.sv
module wbc_match #(
    parameter int TAG_W = 20
) (
    input  logic [TAG_W-1:0]                   req_tag,
    input  logic [wbc_pkg::WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [wbc_pkg::WAYS-1:0]           way_valid,
    input  logic                               mru,
    output logic                               hit,
    output logic                               hit_way,
    output logic                               victim
);
    logic [wbc_pkg::WAYS-1:0] hit_vec;

    for (genvar w = 0; w < wbc_pkg::WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    assign hit     = |hit_vec;
    assign hit_way = hit_vec[1];

    always_comb begin
        if (!way_valid[0]) begin
            victim = 1'b0;
        end else if (!way_valid[1]) begin
            victim = 1'b1;
        end else begin
            victim = ~mru;
        end
    end
endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 8,
    parameter int WORD_W = 32,
    localparam int LINE_W = 8 << OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_done,
    input  logic [LINE_W-1:0] mem_rdata
);
    import wbc_pkg::*;

    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
    localparam int WORDS    = LINE_W / WORD_W;
    localparam int WSEL_W   = $clog2(WORDS);
    localparam int BYTE_OFF = $clog2(WORD_W / 8);
    localparam int WADDR_W  = ADDR_W - BYTE_OFF;
    localparam int IDX_LSB  = OFF_W - BYTE_OFF;
    localparam logic [IDX_W-1:0] LAST_SET = '1;

    typedef struct packed {
        wbc_state_e         st;
        logic [IDX_W-1:0]   sweep;
        logic               we;
        logic [WADDR_W-1:0] waddr;
        logic [WORD_W-1:0]  wdata;
        logic               way;
    } regs_t;

    regs_t r_d, r_q;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_wsel;
    logic [IDX_W-1:0]  wr_idx;

    logic clr, fill_we, dirty_set, mru_we, mru_val;
    logic line_we, word_we;

    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0]             rd_valid;
    logic [WAYS-1:0]             rd_dirty;
    logic                        rd_mru;
    logic [WAYS-1:0][LINE_W-1:0] rd_line;
    logic                        hit, hit_way, victim;
    logic [LINE_W-1:0]           hit_line;

    logic unused_lsb;
    assign unused_lsb = ^cpu_addr[BYTE_OFF-1:0];

    assign req_tag  = r_q.waddr[WADDR_W-1 -: TAG_W];
    assign req_idx  = r_q.waddr[IDX_LSB +: IDX_W];
    assign req_wsel = r_q.waddr[WSEL_W-1:0];
    assign wr_idx   = (r_q.st == ST_SWEEP) ? r_q.sweep : req_idx;

    wbc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rd_idx    (req_idx),
        .wr_idx    (wr_idx),
        .clr       (clr),
        .fill_we   (fill_we),
        .fill_way  (r_q.way),
        .fill_tag  (req_tag),
        .dirty_set (dirty_set),
        .dirty_way (r_q.way),
        .mru_we    (mru_we),
        .mru_val   (mru_val),
        .rd_tag    (rd_tag),
        .rd_valid  (rd_valid),
        .rd_dirty  (rd_dirty),
        .rd_mru    (rd_mru)
    );

    wbc_data_array #(.IDX_W(IDX_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_data (
        .clk       (clk),
        .rd_idx    (req_idx),
        .wr_idx    (req_idx),
        .line_we   (line_we),
        .line_way  (r_q.way),
        .line_data (mem_rdata),
        .word_we   (word_we),
        .word_way  (r_q.way),
        .word_sel  (req_wsel),
        .word_data (r_q.wdata),
        .rd_line   (rd_line)
    );

    wbc_match #(.TAG_W(TAG_W)) u_match (
        .req_tag   (req_tag),
        .way_tag   (rd_tag),
        .way_valid (rd_valid),
        .mru       (rd_mru),
        .hit       (hit),
        .hit_way   (hit_way),
        .victim    (victim)
    );

    assign hit_line  = rd_line[hit_way];
    assign cpu_rdata = hit_line[req_wsel*WORD_W +: WORD_W];
    assign mem_wdata = rd_line[r_q.way];

    always_comb begin
        r_d       = r_q;
        clr       = 1'b0;
        fill_we   = 1'b0;
        dirty_set = 1'b0;
        mru_we    = 1'b0;
        mru_val   = 1'b0;
        line_we   = 1'b0;
        word_we   = 1'b0;
        cpu_ready = 1'b0;
        cpu_done  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {req_tag, req_idx, {OFF_W{1'b0}}};

        unique case (r_q.st)
            ST_SWEEP: begin
                clr = 1'b1;
                if (r_q.sweep == LAST_SET) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.sweep = r_q.sweep + 1'b1;
                end
            end
            ST_IDLE: begin
                cpu_ready = 1'b1;
                if (cpu_req) begin
                    r_d.we    = cpu_we;
                    r_d.waddr = cpu_addr[ADDR_W-1:BYTE_OFF];
                    r_d.wdata = cpu_wdata;
                    r_d.st    = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (hit) begin
                    mru_we  = 1'b1;
                    mru_val = hit_way;
                    r_d.way = hit_way;
                    if (r_q.we) begin
                        r_d.st = ST_WRITE;
                    end else begin
                        cpu_done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end
                end else begin
                    r_d.way = victim;
                    r_d.st  = (rd_valid[victim] && rd_dirty[victim]) ? ST_WBACK : ST_FILL;
                end
            end
            ST_WRITE: begin
                word_we   = 1'b1;
                dirty_set = 1'b1;
                cpu_done  = 1'b1;
                r_d.st    = ST_IDLE;
            end
            ST_WBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {rd_tag[r_q.way], req_idx, {OFF_W{1'b0}}};
                if (mem_done) begin
                    r_d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_done) begin
                    fill_we = 1'b1;
                    line_we = 1'b1;
                    mru_we  = 1'b1;
                    mru_val = r_q.way;
                    r_d.st  = ST_ACCESS;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_SWEEP;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              cpu_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_done,
    input logic [ADDR_W-1:0] mem_addr
);
    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0)); // R1

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done); // R2

    AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_done) |=> (mem_req && !mem_we)); // R5

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done || mem_req) |-> !cpu_ready); // R8

    AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R10
endmodule

bind wb_cache_ctrl wbc_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .cpu_done  (cpu_done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_done  (mem_done),
    .mem_addr  (mem_addr)
);

// File: tb/wb_cache_ctrl_test.sv
module wb_cache_ctrl_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0;
    logic         cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic         cpu_ready, cpu_done;
    logic [31:0]  cpu_rdata;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         mem_done = 1'b0;
    logic [127:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    int wb_count = 0;
    int xfer_count = 0;
    logic [31:0] last_wb_addr = '0;
    int mcnt = 0;

    logic [127:0] bmem [1024];
    logic [31:0]  gold [4096];

    always #5 clk = ~clk;

    wb_cache_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_done(mem_done), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] winit(int a);
        return 32'hC0DE_0000 | 32'(a);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: answers in the 12th cycle of each request
    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt     <= 0;
            mem_done <= 1'b0;
        end else if (mem_req && !mem_done) begin
            if (mcnt == 0) chk(mem_addr[3:0] == 4'h0, "R1 align", mem_addr, {mem_addr[31:4], 4'h0});
            if (mcnt == 10) begin
                mem_done <= 1'b1;
                mcnt     <= 0;
                xfer_count++;
                if (mem_we) begin
                    bmem[mem_addr[13:4]] <= mem_wdata;
                    wb_count++;
                    last_wb_addr <= mem_addr;
                end else begin
                    mem_rdata <= bmem[mem_addr[13:4]];
                end
            end else begin
                mcnt <= mcnt + 1;
            end
        end else begin
            mem_done <= 1'b0;
        end
    end

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [7:0]  cyc;
        logic [1:0]  wbs;
        logic [31:0] wbaddr;
    } vec_t;

    // addr = tag<<12 | set<<4 | word<<2 ; all in set 5 unless noted
    localparam vec_t VECS [16] = '{
        '{1'b0, 32'h0000_0050, 32'h0,         8'd14, 2'd0, 32'h0},      // invalid way 0
        '{1'b0, 32'h0000_0054, 32'h0,         8'd1,  2'd0, 32'h0},      // read hit
        '{1'b1, 32'h0000_0058, 32'h1111_1111, 8'd2,  2'd0, 32'h0},      // write hit
        '{1'b0, 32'h0000_1050, 32'h0,         8'd14, 2'd0, 32'h0},      // invalid way 1
        '{1'b0, 32'h0000_0058, 32'h0,         8'd1,  2'd0, 32'h0},      // hit, T0 recent
        '{1'b0, 32'h0000_205C, 32'h0,         8'd14, 2'd0, 32'h0},      // evict clean T1
        '{1'b0, 32'h0000_1050, 32'h0,         8'd26, 2'd1, 32'h0000_0050}, // evict dirty T0
        '{1'b0, 32'h0000_0058, 32'h0,         8'd14, 2'd0, 32'h0},      // written data back
        '{1'b1, 32'h0000_3054, 32'h2222_2222, 8'd15, 2'd0, 32'h0},      // write miss clean
        '{1'b1, 32'h0000_005C, 32'h3333_3333, 8'd2,  2'd0, 32'h0},      // write hit way 1
        '{1'b1, 32'h0000_1050, 32'h4444_4444, 8'd27, 2'd1, 32'h0000_3050}, // write miss dirty
        '{1'b0, 32'h0000_3054, 32'h0,         8'd26, 2'd1, 32'h0000_0050},
        '{1'b0, 32'h0000_005C, 32'h0,         8'd26, 2'd1, 32'h0000_1050},
        '{1'b0, 32'h0000_1050, 32'h0,         8'd14, 2'd0, 32'h0},
        '{1'b0, 32'h0000_0060, 32'h0,         8'd14, 2'd0, 32'h0},      // set 6
        '{1'b0, 32'h0000_0058, 32'h0,         8'd1,  2'd0, 32'h0}
    };

    function automatic string tag_of(input logic [7:0] c);
        case (c)
            8'd1:    return "R2";
            8'd2:    return "R3";
            8'd14:   return "R4/R7";
            8'd26:   return "R5/R7";
            default: return "R6/R7";
        endcase
    endfunction

    task automatic run_op(input vec_t v);
        int cyc;
        int wb0;
        int xf0;
        int exp_xf;
        string t;
        t = tag_of(v.cyc);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        wb0 = wb_count;
        xf0 = xfer_count;
        cpu_req = 1'b1; cpu_we = v.we; cpu_addr = v.addr; cpu_wdata = v.wdata;
        @(posedge clk); #1;
        cpu_req = 1'b0;
        cyc = 1;
        while (!cpu_done && cyc < 100) begin
            if (cpu_ready) chk(1'b0, "R8 ready during op", 32'(cpu_ready), 32'h0);
            @(posedge clk); #1;
            cyc++;
        end
        chk(cyc == int'(v.cyc), t, 32'(cyc), 32'(v.cyc));
        if (!v.we) chk(cpu_rdata == gold[v.addr[13:2]], t, cpu_rdata, gold[v.addr[13:2]]);
        else gold[v.addr[13:2]] = v.wdata;
        chk(wb_count - wb0 == int'(v.wbs), "R5 writebacks", 32'(wb_count - wb0), 32'(v.wbs));
        exp_xf = (v.cyc <= 2) ? 0 : (v.wbs != 0 ? 2 : 1);
        chk(xfer_count - xf0 == exp_xf, "R10 transfers", 32'(xfer_count - xf0), 32'(exp_xf));
        if (v.wbs != 0) chk(last_wb_addr == v.wbaddr, "R1 wb address", last_wb_addr, v.wbaddr);
    endtask

    task automatic do_reset();
        int n;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!cpu_ready && !cpu_done && !mem_req, "R9 reset outputs",
            {29'h0, cpu_ready, cpu_done, mem_req}, 32'h0);
        rst_n = 1'b1;
        n = 0;
        while (!cpu_ready && n < 1000) begin
            @(posedge clk); #1;
            n++;
        end
        chk(n == 256, "R9 sweep length", 32'(n), 32'd256);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++)
            for (int w = 0; w < 4; w++)
                bmem[i][w*32 +: 32] = winit(i*4 + w);
        for (int i = 0; i < 4096; i++) gold[i] = winit(i);

        do_reset();

        for (int k = 0; k < 16; k++) run_op(VECS[k]);

        // R8: a request raised mid-miss must be ignored
        begin
            int cyc;
            @(negedge clk);
            while (!cpu_ready) @(negedge clk);
            cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'h70; cpu_wdata = '0;
            @(posedge clk); #1;
            cpu_req = 1'b0;
            cyc = 1;
            while (!cpu_done && cyc < 100) begin
                @(posedge clk); #1;
                cyc++;
                if (cyc == 3) begin
                    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 32'h74; cpu_wdata = 32'hDEAD_BEEF;
                end
                if (cyc == 4) cpu_req = 1'b0;
            end
            chk(cyc == 14, "R8 miss unaffected", 32'(cyc), 32'd14);
            chk(cpu_rdata == gold[12'h1C], "R8 read data", cpu_rdata, gold[12'h1C]);
        end
        run_op('{1'b0, 32'h74, 32'h0, 8'd1, 2'd0, 32'h0});

        // R9: reset invalidates a line that was resident
        do_reset();
        run_op('{1'b0, 32'h58, 32'h0, 8'd14, 2'd0, 32'h0});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule